// File: doc/BRIEF.md
# I2C Target Register Bridge

This block sits behind an I2C bit-level front end and turns byte-wise register transfers into single 32-bit accesses on a parallel register bus. The front end delivers decoded events: start of a write transfer, start of a read transfer, stop, each received byte, and each request for a byte to transmit. The bridge answers every received byte with ACK or NAK one cycle later. It presents each requested byte one cycle after the request.

The first byte of a write transfer selects a register. Most registers are staged in a small buffer and reach the bus as one word when stop arrives. The data FIFO register is the exception: its bytes pass through one at a time, in both directions. A locality selector and a checksum-enable flag live inside the bridge. The locality is placed in the upper bits of every bus address. A 4-byte status register can be reached at four consecutive indices for partial access.

Bus requests are combinational in the cycle of the triggering event. The register file behind the bus must return `bus_rdata_i` in that same cycle. `bus_be_o` is 4'b1111 for a word access and 4'b0001 for a single-byte access. Data is right-justified.

Top module: `i2c_regbus_bridge`

## Requirements
- R1: The first byte of a write transfer is a register index. The accepted indices are 0x00 (locality), 0x04 (access), 0x08 (interrupt enable), 0x14 (interrupt capability), 0x24 (FIFO), 0x28 to 0x2B (status) and 0x40 (checksum enable), and each is ACKed. Any other index, and the device-address index 0x38, is NAKed, as is every further byte until the next start-write.
- R2: After a non-FIFO index, up to four data bytes are ACKed. Any byte beyond that is NAKed.
- R3: For non-FIFO bus registers, the data bytes form a little-endian word, with unwritten bytes zero. That word is written to the bus as a 4-byte access only at stop, and only if at least one data byte arrived. Nothing reaches the bus before stop.
- R4: Every data byte written to index 0x24 becomes a 1-byte bus write at the same cycle, with no limit on the count. Nothing is written at stop.
- R5: A write of value v to index 0x00 sets the locality if v < NUM_LOC and is otherwise ignored. Reading index 0x00 returns the locality. Bus address = {locality, register offset}, with the locality starting at bit LOC_SHIFT. The bus offsets are access 0x00, interrupt enable 0x08, status 0x18 and FIFO 0x24.
- R6: Writing index 0x40 stores only bit 0 of the data. Reading index 0x40 returns that bit. No bus access is made in either case.
- R7: A status write at index 0x28+N with N>0 is a 1-byte bus write at offset 0x18+N. Its data is the first byte ANDed with STS_WR_MASK shifted right by 8·N. With N=0 it is a 4-byte write of the word ANDed with STS_WR_MASK.
- R8: The first byte requested after an index write fetches the register once. Four bytes are then served LSB first. Further requests return 0xFF.
- R9: A status read at index 0x28+N returns the bus word with bits 31:26 cleared, shifted right by 8·N.
- R10: Every byte read at index 0x24 is a fresh 1-byte bus read. No byte is cached.
- R11: Interrupt-enable writes are ANDed with INT_MASK. Reading index 0x14 returns INT_MASK.
- R12: Reset sets the locality to 0 and clears the checksum flag. Stop and start-write discard the transaction. A read with no index written returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_wr_i | input | 1 | Start of write transfer |
| start_rd_i | input | 1 | Start of read transfer |
| stop_i | input | 1 | Stop condition |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_byte_i | input | 8 | Received byte |
| ack_valid_o | output | 1 | Response for the previous received byte |
| ack_o | output | 1 | 1 = ACK, 0 = NAK |
| tx_req_i | input | 1 | Request for a byte to transmit |
| tx_valid_o | output | 1 | Transmit byte valid |
| tx_byte_o | output | 8 | Transmit byte |
| bus_wr_o | output | 1 | Bus write strobe |
| bus_rd_o | output | 1 | Bus read strobe |
| bus_addr_o | output | ADDR_W (15) | Bus byte address including locality |
| bus_be_o | output | 4 | 4'b1111 word, 4'b0001 single byte |
| bus_wdata_o | output | 32 | Bus write data |
| bus_rdata_i | input | 32 | Bus read data, same cycle |

## Verification
The bench uses the default parameters: NUM_LOC=5, LOC_SHIFT=12, and status and interrupt masks whose bytes differ in every lane. With NUM_LOC=5, the value 5 is the first locality that must be refused, and 7 still fits the 3-bit field, so both out-of-range paths are reachable. The distinct mask bytes make each status sub-byte shift visible in the data. The bench register file returns an address-derived pattern with high bits set, so the cleared status bits show in the read data. Its FIFO source counts up on every read, so a cached FIFO byte would show as a repeated value.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;
  typedef enum logic [1:0] {OP_IDLE, OP_WR, OP_RD} op_e;
  typedef enum logic [3:0] {
    RK_BAD, RK_LOC, RK_ACC, RK_INTEN, RK_INTCAP, RK_FIFO, RK_STS, RK_DEVADR, RK_CSUM
  } reg_kind_e;

  localparam logic [7:0] IDX_LOC    = 8'h00;
  localparam logic [7:0] IDX_ACC    = 8'h04;
  localparam logic [7:0] IDX_INTEN  = 8'h08;
  localparam logic [7:0] IDX_INTCAP = 8'h14;
  localparam logic [7:0] IDX_FIFO   = 8'h24;
  localparam logic [7:0] IDX_STS    = 8'h28;
  localparam logic [7:0] IDX_DEVADR = 8'h38;
  localparam logic [7:0] IDX_CSUM   = 8'h40;

  localparam logic [7:0] BOFF_ACC   = 8'h00;
  localparam logic [7:0] BOFF_INTEN = 8'h08;
  localparam logic [7:0] BOFF_STS   = 8'h18;
  localparam logic [7:0] BOFF_FIFO  = 8'h24;
endpackage

// File: rtl/i2cb_idx_decode.sv
module i2cb_idx_decode import i2cb_pkg::*; (
  input  logic [7:0] idx_i,
  output reg_kind_e  kind_o,
  output logic [1:0] sub_o,
  output logic [7:0] boff_o
);
  always_comb begin
    kind_o = RK_BAD;
    sub_o  = 2'd0;
    boff_o = 8'h00;
    if (idx_i[7:2] == IDX_STS[7:2]) begin
      kind_o = RK_STS;
      sub_o  = idx_i[1:0];
      boff_o = BOFF_STS;
    end else begin
      case (idx_i)
        IDX_LOC:    kind_o = RK_LOC;
        IDX_ACC:    begin kind_o = RK_ACC;   boff_o = BOFF_ACC;   end
        IDX_INTEN:  begin kind_o = RK_INTEN; boff_o = BOFF_INTEN; end
        IDX_INTCAP: kind_o = RK_INTCAP;
        IDX_FIFO:   begin kind_o = RK_FIFO;  boff_o = BOFF_FIFO;  end
        IDX_DEVADR: kind_o = RK_DEVADR;
        IDX_CSUM:   kind_o = RK_CSUM;
        default:    kind_o = RK_BAD;
      endcase
    end
  end
endmodule

// File: rtl/i2cb_wr_fmt.sv
module i2cb_wr_fmt import i2cb_pkg::*; #(
  parameter logic [31:0] STS_WR_MASK = 32'h0C40_02E6,
  parameter logic [31:0] INT_MASK    = 32'h8000_00C7
) (
  input  reg_kind_e   kind_i,
  input  logic [1:0]  sub_i,
  input  logic [31:0] word_i,
  output logic [31:0] wdata_o,
  output logic [3:0]  be_o,
  output logic [1:0]  lane_o
);
  logic [31:0] sts_mask_sh;
  assign sts_mask_sh = STS_WR_MASK >> {sub_i, 3'b000};

  always_comb begin
    wdata_o = word_i;
    be_o    = 4'b1111;
    lane_o  = 2'd0;
    case (kind_i)
      RK_INTEN: wdata_o = word_i & INT_MASK;
      RK_STS: begin
        if (sub_i == 2'd0) begin
          wdata_o = word_i & STS_WR_MASK;
        end else begin
          // sub-byte status write: single lane, shifted mask
          wdata_o = {24'h0, word_i[7:0] & sts_mask_sh[7:0]};
          be_o    = 4'b0001;
          lane_o  = sub_i;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/i2cb_rd_fmt.sv
module i2cb_rd_fmt import i2cb_pkg::*; #(
  parameter int          LOC_W       = 3,
  parameter logic [31:0] STS_RD_MASK = 32'h03FF_FFFF,
  parameter logic [31:0] INT_MASK    = 32'h8000_00C7
) (
  input  reg_kind_e        kind_i,
  input  logic [1:0]       sub_i,
  input  logic [31:0]      rdata_i,
  input  logic [LOC_W-1:0] loc_i,
  input  logic             csum_i,
  output logic [31:0]      word_o
);
  always_comb begin
    case (kind_i)
      RK_LOC:    word_o = 32'(loc_i);
      RK_CSUM:   word_o = {31'h0, csum_i};
      RK_INTCAP: word_o = INT_MASK;
      RK_FIFO:   word_o = {24'h0, rdata_i[7:0]};
      RK_STS:    word_o = (rdata_i & STS_RD_MASK) >> {sub_i, 3'b000};
      default:   word_o = rdata_i;
    endcase
  end
endmodule

// File: rtl/i2c_regbus_bridge.sv
module i2c_regbus_bridge import i2cb_pkg::*; #(
  parameter int          NUM_LOC     = 5,
  parameter int          LOC_SHIFT   = 12,
  parameter logic [31:0] STS_WR_MASK = 32'h0C40_02E6,
  parameter logic [31:0] STS_RD_MASK = 32'h03FF_FFFF,
  parameter logic [31:0] INT_MASK    = 32'h8000_00C7,
  localparam int LOC_W  = (NUM_LOC > 1) ? $clog2(NUM_LOC) : 1,
  localparam int ADDR_W = LOC_SHIFT + LOC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_wr_i,
  input  logic              start_rd_i,
  input  logic              stop_i,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_byte_i,
  output logic              ack_valid_o,
  output logic              ack_o,
  input  logic              tx_req_i,
  output logic              tx_valid_o,
  output logic [7:0]        tx_byte_o,
  output logic              bus_wr_o,
  output logic              bus_rd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [3:0]        bus_be_o,
  output logic [31:0]       bus_wdata_o,
  input  logic [31:0]       bus_rdata_i
);
  localparam int         BUF_N   = 5;  // index + 4 data bytes
  localparam logic [2:0] OFF_END = 3'(BUF_N);

  op_e              op_q;
  logic [7:0]       idx_q;
  logic [3:0][7:0]  dat_q;
  logic [2:0]       off_q;
  logic             rej_q;
  logic [LOC_W-1:0] loc_q;
  logic             csum_q;
  logic             ack_vld_q, ack_q, tx_vld_q;
  logic [7:0]       tx_q;

  // one decoder: incoming index byte while idle, stored index otherwise
  logic       dec_sel_rx;
  logic [7:0] dec_in;
  reg_kind_e  cur_kind;
  logic [1:0] cur_sub;
  logic [7:0] cur_boff;

  assign dec_sel_rx = rx_valid_i && (op_q == OP_IDLE);
  assign dec_in     = dec_sel_rx ? rx_byte_i : idx_q;

  i2cb_idx_decode u_dec (
    .idx_i (dec_in),
    .kind_o(cur_kind),
    .sub_o (cur_sub),
    .boff_o(cur_boff)
  );

  logic [31:0] fmt_wdata;
  logic [3:0]  fmt_be;
  logic [1:0]  fmt_lane;
  logic [31:0] fetched_w;

  i2cb_wr_fmt #(.STS_WR_MASK(STS_WR_MASK), .INT_MASK(INT_MASK)) u_wr_fmt (
    .kind_i (cur_kind),
    .sub_i  (cur_sub),
    .word_i (dat_q),
    .wdata_o(fmt_wdata),
    .be_o   (fmt_be),
    .lane_o (fmt_lane)
  );

  i2cb_rd_fmt #(.LOC_W(LOC_W), .STS_RD_MASK(STS_RD_MASK), .INT_MASK(INT_MASK)) u_rd_fmt (
    .kind_i (cur_kind),
    .sub_i  (cur_sub),
    .rdata_i(bus_rdata_i),
    .loc_i  (loc_q),
    .csum_i (csum_q),
    .word_o (fetched_w)
  );

  logic       rx_idx, idx_ok, rx_dat, fifo_wr, buf_wr, rx_ack;
  logic       commit, commit_bus, fetch, fetch_bus, live_rd, is_fifo;
  logic [2:0] slot;

  assign is_fifo    = (cur_kind == RK_FIFO);
  assign slot       = off_q - 3'd1;
  assign rx_idx     = dec_sel_rx && !rej_q;
  assign idx_ok     = (cur_kind != RK_BAD) && (cur_kind != RK_DEVADR);
  assign rx_dat     = rx_valid_i && (op_q == OP_WR);
  assign fifo_wr    = rx_dat && is_fifo;
  assign buf_wr     = rx_dat && !is_fifo && (off_q < OFF_END);
  assign rx_ack     = rx_idx ? idx_ok : (fifo_wr || buf_wr);
  assign commit     = stop_i && (op_q == OP_WR) && (off_q > 3'd1) && !is_fifo;
  assign commit_bus = commit && (cur_kind inside {RK_ACC, RK_INTEN, RK_STS});
  assign fetch      = tx_req_i && (op_q == OP_WR) && (off_q == 3'd1);
  assign fetch_bus  = fetch && (cur_kind inside {RK_ACC, RK_INTEN, RK_FIFO, RK_STS});
  assign live_rd    = tx_req_i && (op_q == OP_RD) && is_fifo;

  assign bus_wr_o    = fifo_wr || commit_bus;
  assign bus_rd_o    = fetch_bus || live_rd;
  assign bus_wdata_o = fifo_wr ? {24'h0, rx_byte_i} : fmt_wdata;
  assign bus_be_o    = bus_wr_o ? (fifo_wr ? 4'b0001 : fmt_be)
                                : (is_fifo ? 4'b0001 : 4'b1111);
  assign bus_addr_o  = {loc_q, {(LOC_SHIFT-8){1'b0}},
                        cur_boff + (commit_bus ? {6'h0, fmt_lane} : 8'h00)};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q      <= OP_IDLE;
      idx_q     <= '0;
      dat_q     <= '0;
      off_q     <= '0;
      rej_q     <= 1'b0;
      loc_q     <= '0;
      csum_q    <= 1'b0;
      ack_vld_q <= 1'b0;
      ack_q     <= 1'b0;
      tx_vld_q  <= 1'b0;
      tx_q      <= 8'hFF;
    end else begin
      ack_vld_q <= rx_valid_i;
      ack_q     <= rx_valid_i && rx_ack;
      tx_vld_q  <= tx_req_i;
      if (start_wr_i || stop_i) begin
        if (commit && cur_kind == RK_LOC && 32'(dat_q[0]) < NUM_LOC)
          loc_q <= dat_q[0][LOC_W-1:0];
        if (commit && cur_kind == RK_CSUM)
          csum_q <= dat_q[0][0];
        op_q  <= OP_IDLE;
        idx_q <= '0;
        dat_q <= '0;
        off_q <= '0;
        rej_q <= 1'b0;
      end else if (rx_valid_i) begin
        if (rx_idx) begin
          if (idx_ok) begin
            idx_q <= rx_byte_i;
            op_q  <= OP_WR;
            off_q <= 3'd1;
          end else begin
            rej_q <= 1'b1;
          end
        end else if (buf_wr) begin
          dat_q[slot[1:0]] <= rx_byte_i;
          off_q            <= off_q + 3'd1;
        end
      end else if (tx_req_i) begin
        if (fetch) begin
          dat_q <= fetched_w;
          off_q <= 3'd2;
          op_q  <= OP_RD;
          tx_q  <= fetched_w[7:0];
        end else if (live_rd) begin
          tx_q <= bus_rdata_i[7:0];
        end else if (op_q == OP_RD && off_q < OFF_END) begin
          tx_q  <= dat_q[slot[1:0]];
          off_q <= off_q + 3'd1;
        end else begin
          op_q  <= OP_RD;
          off_q <= OFF_END;
          tx_q  <= 8'hFF;
        end
      end
    end
  end

  assign ack_valid_o = ack_vld_q;
  assign ack_o       = ack_q;
  assign tx_valid_o  = tx_vld_q;
  assign tx_byte_o   = tx_q;

  AST_ACK_AFTER_RX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_valid_o |-> $past(rx_valid_i)); // R1
  AST_OFF_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_q <= OFF_END); // R2
  AST_WR_AT_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_o && !is_fifo) |-> stop_i); // R3
  AST_FIFO_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_o && is_fifo) |-> (bus_be_o == 4'b0001 && bus_wdata_o[31:8] == 24'h0)); // R4
  AST_LOC_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(loc_q) < NUM_LOC); // R5
  AST_LOC_AT_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(loc_q) |-> $past(stop_i)); // R5
  AST_CSUM_AT_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(csum_q) |-> $past(stop_i)); // R6
  AST_RD_WR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_wr_o && bus_rd_o)); // R10
endmodule

// File: tb/i2c_regbus_bridge_test.sv
`timescale 1ns/1ps
module i2c_regbus_bridge_test;
  localparam int ADDR_W = 15;
  localparam logic [31:0] STS_WR_MASK = 32'h0C40_02E6;
  localparam logic [31:0] STS_RD_MASK = 32'h03FF_FFFF;
  localparam logic [31:0] INT_MASK    = 32'h8000_00C7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_wr = 0, start_rd = 0, stop = 0, rx_valid = 0, tx_req = 0;
  logic [7:0] rx_byte = 0;
  logic ack_valid, ack, tx_valid, bus_wr, bus_rd;
  logic [7:0] tx_byte;
  logic [ADDR_W-1:0] bus_addr;
  logic [3:0] bus_be;
  logic [31:0] bus_wdata, bus_rdata;

  always #2.5 clk = ~clk;

  i2c_regbus_bridge #(.NUM_LOC(5), .LOC_SHIFT(12), .STS_WR_MASK(STS_WR_MASK),
    .STS_RD_MASK(STS_RD_MASK), .INT_MASK(INT_MASK)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_wr_i(start_wr), .start_rd_i(start_rd),
    .stop_i(stop), .rx_valid_i(rx_valid), .rx_byte_i(rx_byte),
    .ack_valid_o(ack_valid), .ack_o(ack), .tx_req_i(tx_req),
    .tx_valid_o(tx_valid), .tx_byte_o(tx_byte), .bus_wr_o(bus_wr),
    .bus_rd_o(bus_rd), .bus_addr_o(bus_addr), .bus_be_o(bus_be),
    .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata));

  // register file model
  logic [7:0] fifo_ctr = 8'h50;
  int rd_cnt = 0;
  function automatic logic [31:0] model(input logic [ADDR_W-1:0] a);
    logic [15:0] w;
    w = 16'(a);
    return {~w, w};
  endfunction
  assign bus_rdata = (bus_addr[7:0] == 8'h24) ? {24'h0, fifo_ctr} : model(bus_addr);
  always @(posedge clk) begin
    if (bus_rd) begin
      rd_cnt <= rd_cnt + 1;
      if (bus_addr[7:0] == 8'h24) fifo_ctr <= fifo_ctr + 8'd1;
    end
  end

  function automatic logic [ADDR_W-1:0] ba(input int loc, input logic [7:0] off);
    return {3'(loc), 4'h0, off};
  endfunction

  typedef struct packed {logic [ADDR_W-1:0] a; logic [3:0] be; logic [31:0] d;} wr_t;
  logic qa[$];  string qa_r[$];
  logic [7:0] qt[$]; string qt_r[$];
  wr_t qw[$];   string qw_r[$];
  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (bus_wr) begin
        if (qw.size() == 0) chk("R3 unexpected bus write", 32'(bus_addr), 32'hFFFF_FFFF);
        else begin
          wr_t e; string r;
          e = qw.pop_front(); r = qw_r.pop_front();
          chk(r, 32'({bus_addr, bus_be}), 32'({e.a, e.be}));
          chk(r, bus_wdata, e.d);
        end
      end
      if (ack_valid) begin
        if (qa.size() == 0) chk("R1 unexpected ack", 32'(ack), 32'hFFFF_FFFF);
        else begin
          logic e; string r;
          e = qa.pop_front(); r = qa_r.pop_front();
          chk(r, 32'(ack), 32'(e));
        end
      end
      if (tx_valid) begin
        if (qt.size() == 0) chk("R8 unexpected tx", 32'(tx_byte), 32'hFFFF_FFFF);
        else begin
          logic [7:0] e; string r;
          e = qt.pop_front(); r = qt_r.pop_front();
          chk(r, 32'(tx_byte), 32'(e));
        end
      end
    end
  end

  task automatic clr();
    start_wr = 0; start_rd = 0; stop = 0; rx_valid = 0; tx_req = 0;
  endtask
  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); clr(); end
  endtask
  task automatic ev_start_wr(); @(negedge clk); clr(); start_wr = 1; endtask
  task automatic ev_start_rd(); @(negedge clk); clr(); start_rd = 1; endtask
  task automatic ev_stop();     @(negedge clk); clr(); stop = 1; endtask
  task automatic wr_byte(input logic [7:0] b, input logic exp_ack, input string r);
    @(negedge clk); clr(); rx_valid = 1; rx_byte = b;
    qa.push_back(exp_ack); qa_r.push_back(r);
  endtask
  task automatic rd_byte(input logic [7:0] e, input string r);
    @(negedge clk); clr(); tx_req = 1;
    qt.push_back(e); qt_r.push_back(r);
  endtask
  task automatic exp_wr(input logic [ADDR_W-1:0] a, input logic [3:0] be,
                        input logic [31:0] d, input string r);
    wr_t e;
    e.a = a; e.be = be; e.d = d;
    qw.push_back(e); qw_r.push_back(r);
  endtask
  task automatic reg_write(input logic [7:0] idx, input int n, input logic [31:0] w,
                           input string r);
    ev_start_wr();
    wr_byte(idx, 1'b1, r);
    for (int i = 0; i < n; i++) wr_byte(w[8*i +: 8], 1'b1, r);
    ev_stop();
    idle(1);
  endtask
  task automatic reg_read(input logic [7:0] idx, input int n, input logic [31:0] w,
                          input string r);
    ev_start_wr();
    wr_byte(idx, 1'b1, r);
    ev_start_rd();
    for (int i = 0; i < n; i++) rd_byte((i < 4) ? w[8*i +: 8] : 8'hFF, r);
    ev_stop();
    idle(1);
  endtask

  initial begin
    int rc0;
    logic [7:0] f0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R12 reset ack_valid", 32'(ack_valid), 0);
    chk("R12 reset tx_valid", 32'(tx_valid), 0);
    chk("R12 reset bus idle", 32'({bus_wr, bus_rd}), 0);
    idle(1);

    // R12: read without index, reset locality and checksum
    ev_start_rd(); rd_byte(8'hFF, "R12 read w/o index"); ev_stop(); idle(1);
    reg_read(8'h00, 4, 32'h0, "R12 reset locality");
    reg_read(8'h40, 4, 32'h0, "R12 reset checksum flag");

    // R1: index rejection
    ev_start_wr(); wr_byte(8'h77, 1'b0, "R1 unknown index");
    wr_byte(8'h04, 1'b0, "R1 sticky reject"); ev_stop(); idle(1);
    ev_start_wr(); wr_byte(8'h38, 1'b0, "R1 device address"); ev_stop(); idle(1);
    ev_start_wr(); wr_byte(8'h3C, 1'b0, "R1 unmapped index"); ev_stop(); idle(1);

    // R2 / R3: buffered writes committed at stop
    ev_start_wr(); wr_byte(8'h04, 1'b1, "R2 index");
    for (int i = 0; i < 4; i++) wr_byte(8'h11 * 8'(i + 1), 1'b1, "R2 data ack");
    wr_byte(8'h55, 1'b0, "R2 fifth byte nak");
    exp_wr(ba(0, 8'h00), 4'hF, 32'h4433_2211, "R3 full word at stop");
    ev_stop(); idle(1);
    exp_wr(ba(0, 8'h00), 4'hF, 32'h0000_BBAA, "R3 partial word");
    reg_write(8'h04, 2, 32'h0000_BBAA, "R3 partial");
    reg_write(8'h04, 0, 32'h0, "R3 index only no write");

    // R11: interrupt enable mask and capability
    exp_wr(ba(0, 8'h08), 4'hF, INT_MASK, "R11 int enable masked");
    reg_write(8'h08, 4, 32'hFFFF_FFFF, "R11 int enable");
    reg_read(8'h14, 5, INT_MASK, "R11 int capability");

    // R5: locality
    reg_write(8'h00, 1, 32'h3, "R5 set locality 3");
    exp_wr(ba(3, 8'h00), 4'hF, 32'h0000_0001, "R5 locality in address");
    reg_write(8'h04, 1, 32'h1, "R5 access write");
    reg_read(8'h00, 4, 32'h3, "R5 read locality");
    reg_write(8'h00, 1, 32'h7, "R5 invalid 7");
    reg_read(8'h00, 4, 32'h3, "R5 invalid 7 ignored");
    reg_write(8'h00, 1, 32'h5, "R5 invalid 5");
    reg_read(8'h00, 4, 32'h3, "R5 invalid 5 ignored");

    // R8: single fetch, LSB first, then 0xFF
    rc0 = rd_cnt;
    reg_read(8'h04, 6, model(ba(3, 8'h00)), "R8 access read");
    chk("R8 one bus fetch", 32'(rd_cnt - rc0), 1);
    reg_write(8'h00, 1, 32'h0, "R5 locality back to 0");

    // R6: checksum flag
    reg_write(8'h40, 1, 32'hFF, "R6 set flag");
    reg_read(8'h40, 4, 32'h1, "R6 read flag set");
    reg_write(8'h40, 1, 32'h02, "R6 bit0 only");
    reg_read(8'h40, 4, 32'h0, "R6 read flag clear");

    // R4: FIFO streaming writes
    ev_start_wr(); wr_byte(8'h24, 1'b1, "R4 fifo index");
    for (int i = 0; i < 6; i++) begin
      exp_wr(ba(0, 8'h24), 4'b0001, 32'(8'h10 + 8'(i)), "R4 fifo byte write");
      wr_byte(8'h10 + 8'(i), 1'b1, "R4 fifo byte ack");
    end
    ev_stop(); idle(1);

    // R7: status writes
    exp_wr(ba(0, 8'h18), 4'hF, STS_WR_MASK, "R7 status word");
    reg_write(8'h28, 4, 32'hFFFF_FFFF, "R7 status word");
    exp_wr(ba(0, 8'h19), 4'b0001, 32'h02, "R7 status byte 1");
    reg_write(8'h29, 1, 32'hFF, "R7 status byte 1");
    exp_wr(ba(0, 8'h1A), 4'b0001, 32'h40, "R7 status byte 2");
    reg_write(8'h2A, 1, 32'hFF, "R7 status byte 2");
    exp_wr(ba(0, 8'h1B), 4'b0001, 32'h0C, "R7 status byte 3");
    reg_write(8'h2B, 1, 32'h0F, "R7 status byte 3");

    // R9: status reads
    reg_read(8'h28, 5, model(ba(0, 8'h18)) & STS_RD_MASK, "R9 status read base");
    reg_read(8'h2A, 4, (model(ba(0, 8'h18)) & STS_RD_MASK) >> 16, "R9 status read +2");
    reg_read(8'h2B, 4, (model(ba(0, 8'h18)) & STS_RD_MASK) >> 24, "R9 status read +3");

    // R10: live FIFO reads
    f0 = fifo_ctr;
    ev_start_wr(); wr_byte(8'h24, 1'b1, "R10 fifo index"); ev_start_rd();
    for (int i = 0; i < 6; i++) rd_byte(f0 + 8'(i), "R10 fifo live byte");
    ev_stop(); idle(1);

    // R12: stop discards transaction
    ev_start_rd(); rd_byte(8'hFF, "R12 read after stop"); ev_stop(); idle(3);

    chk("R3 pending writes", 32'(qw.size()), 0);
    chk("R1 pending acks", 32'(qa.size()), 0);
    chk("R8 pending tx", 32'(qt.size()), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired R12 actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule